// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block turns a single audio kernel clock into the timing that an audio serial port needs: an optional master clock for an external converter, a bit clock for the serial line, a one-cycle bit tick that tells the serializer when to shift, and a frame tick on the last bit of every stereo frame. All outputs are built from the kernel clock. Every edge lands on a kernel-clock edge, and no second clock domain is created.

The core is a programmable divider whose ratio is N = 2*div + odd. The 8-bit `div` and the single `odd` bit together give any ratio from 4 to 511, odd values included. An odd ratio gives a high phase one kernel cycle shorter than the low phase. In direct mode the bit clock has period N. In master-clock mode the divided clock is the master clock, which runs at 256 times the sample rate. The bit clock is then that master clock divided by 8 for 16-bit channels or by 4 for 32-bit channels. The settings are sampled only while the generator is disabled. Enabling it starts every counter from zero.

Top module: `audio_clkgen`

## Requirements
- R1: While `run_en` is low, and from the first clock edge that samples it low, `mclk_o`, `bclk_o`, `bit_tick` and `frame_tick` are all 0. After reset every output is 0.
- R2: The ratio is N = 2*`div_i` + `odd_i`. In direct mode (`mclk_mode`=0) `bclk_o` has period N kernel cycles. It is high for the first floor(N/2) cycles and low for the rest.
- R3: A programmed ratio below 4 (`div_i` of 0 or 1) acts as N = 4. The largest ratio, `div_i`=255 with `odd_i`=1, gives N = 511.
- R4: `bit_tick` is high for exactly one kernel cycle, the last cycle of each bit-clock period. `bclk_o` is low in that cycle.
- R5: `frame_tick` is high together with `bit_tick` on the last bit of every frame. A frame is 32 bits when `wide_ch`=0 (16-bit channels) and 64 bits when `wide_ch`=1 (32-bit channels).
- R6: In master-clock mode (`mclk_mode`=1) the master clock has period N with the R2 duty. `bclk_o` then has period 8*N when `wide_ch`=0 and 4*N when `wide_ch`=1, and is high for the first half of that period.
- R7: `mclk_oe` gates `mclk_o` directly, with no delay. `mclk_o` is always 0 in direct mode.
- R8: `div_i`, `odd_i`, `mclk_mode` and `wide_ch` are captured on every clock edge that samples `run_en` low. Changes made while enabled have no effect until the next disable and enable.
- R9: In the first cycle after the edge that samples `run_en` high, every counter is at zero. The bit clock (and the master clock, if it is on) starts high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable; settings load while it is low |
| div_i | input | 8 | Divider half-ratio field |
| odd_i | input | 1 | Adds one to the ratio |
| mclk_mode | input | 1 | 1: master-clock mode (256x sample rate) |
| mclk_oe | input | 1 | Drives the master clock onto `mclk_o` |
| wide_ch | input | 1 | 1: 32-bit channels, 0: 16-bit channels |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Serial bit clock |
| bit_tick | output | 1 | One-cycle pulse on the last cycle of each bit |
| frame_tick | output | 1 | One-cycle pulse on the last bit of each frame |

## Verification
The bound checker checks these rules on every cycle: outputs are quiet after a disabled cycle, a tick pulse never lasts two cycles, the bit clock is low under a tick and high just after one, a frame tick always has a bit tick, and `mclk_o` is never high without its enable. Exact periods, duty for odd ratios, ratio clamping, frame lengths for both channel widths, and the capture of settings only while disabled can be shown only by the bench scenarios. The bench compares every output against a cycle-count model of the requirements.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W     = 8,
  parameter int MIN_RATIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_mode,
  input  logic             mclk_oe,
  input  logic             wide_ch,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             bit_tick,
  output logic             frame_tick
);
  localparam int RW = DIV_W + 1;

  logic             run;
  logic [DIV_W-1:0] div_q;
  logic             odd_q, mode_q, wide_q;
  logic [RW-1:0]    cnt;
  logic [2:0]       sub;
  logic [5:0]       bitc;

  logic [RW-1:0] ratio_raw, ratio, half;
  logic          base_last, sub_last, bit_last, frame_last, base_hi;

  assign ratio_raw  = {div_q, odd_q};
  assign ratio      = (ratio_raw < RW'(MIN_RATIO)) ? RW'(MIN_RATIO) : ratio_raw;
  assign half       = ratio >> 1;
  assign base_last  = (cnt == ratio - RW'(1));
  assign base_hi    = (cnt < half);
  assign sub_last   = mode_q ? (sub == (wide_q ? 3'd3 : 3'd7)) : 1'b1;
  assign bit_last   = base_last & sub_last;
  assign frame_last = (bitc == (wide_q ? 6'd63 : 6'd31));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      div_q  <= '0;
      odd_q  <= 1'b0;
      mode_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      run <= run_en;
      if (!run_en) begin
        div_q  <= div_i;
        odd_q  <= odd_i;
        mode_q <= mclk_mode;
        wide_q <= wide_ch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sub  <= '0;
      bitc <= '0;
    end else if (!run) begin
      cnt  <= '0;
      sub  <= '0;
      bitc <= '0;
    end else begin
      cnt <= base_last ? '0 : cnt + RW'(1);
      if (base_last)
        sub <= sub_last ? 3'd0 : sub + 3'd1;
      if (bit_last)
        bitc <= frame_last ? 6'd0 : bitc + 6'd1;
    end
  end

  assign mclk_o     = run & mode_q & mclk_oe & base_hi;
  assign bclk_o     = run & (mode_q ? (sub < (wide_q ? 3'd2 : 3'd4)) : base_hi);
  assign bit_tick   = run & bit_last;
  assign frame_tick = bit_tick & frame_last;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic mclk_oe,
  input logic mclk_o,
  input logic bclk_o,
  input logic bit_tick,
  input logic frame_tick
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> !(mclk_o | bclk_o | bit_tick | frame_tick));
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
  a_r4_bclk_low_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> !bclk_o);
  a_r9_bclk_high_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && run_en) |=> bclk_o);
  a_r5_frame_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> bit_tick);
  a_r7_mclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_o |-> mclk_oe);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (.*);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic clk = 0, rst_n = 0, run_en = 0, odd_i = 0, mclk_mode = 0, mclk_oe = 0, wide_ch = 0;
  logic [7:0] div_i = 0;
  logic mclk_o, bclk_o, bit_tick, frame_tick;
  int n_chk = 0, n_bad = 0;
  int e_n; logic e_mode, e_wide;

  audio_clkgen uut (.*);

  always #5 clk = ~clk;

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic cmp(string req, logic [3:0] act, logic [3:0] exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual {mclk,bclk,tick,frame}=%b expected %b", req, k, act, exp);
    end
  endtask

  function automatic logic [3:0] model(int k);
    int c, m, s, bit_i, f;
    logic mc, bc, bt, fr;
    c = k % e_n;
    f = e_wide ? 64 : 32;
    if (!e_mode) begin
      mc = 0; bc = c < e_n / 2; bt = c == e_n - 1; bit_i = k / e_n;
    end else begin
      m = e_wide ? 4 : 8;
      s = (k / e_n) % m;
      mc = mclk_oe && (c < e_n / 2);
      bc = s < m / 2; bt = (c == e_n - 1) && (s == m - 1); bit_i = k / (e_n * m);
    end
    fr = bt && (bit_i % f == f - 1);
    return {mc, bc, bt, fr};
  endfunction

  // load settings while disabled, check quiet outputs (R1), then enable
  task automatic start(logic [7:0] d, logic o, logic md, logic w);
    int r;
    @(negedge clk);
    run_en = 0; div_i = d; odd_i = o; mclk_mode = md; wide_ch = w;
    @(negedge clk);
    cmp("R1", {mclk_o, bclk_o, bit_tick, frame_tick}, 4'b0000, -1);
    r = 2 * d + o;
    e_n = (r < 4) ? 4 : r; e_mode = md; e_wide = w;
    run_en = 1;
  endtask

  task automatic run_cycles(string req, int k0, int cycles);
    for (int k = k0; k < k0 + cycles; k++) begin
      @(negedge clk);
      cmp(req, {mclk_o, bclk_o, bit_tick, frame_tick}, model(k), k);
    end
  endtask

  task automatic t_reset;
    cmp("R1", {mclk_o, bclk_o, bit_tick, frame_tick}, 4'b0000, -1);
  endtask

  task automatic t_direct_even;  start(8'd2, 0, 0, 0); run_cycles("R2_R5_R9", 0, 300); endtask
  task automatic t_direct_odd;   start(8'd2, 1, 0, 1); run_cycles("R2_R4", 0, 400); endtask
  task automatic t_clamp;        start(8'd1, 1, 0, 0); run_cycles("R3", 0, 200);
                                 start(8'd0, 0, 0, 0); run_cycles("R3", 0, 200); endtask
  task automatic t_max;          start(8'd255, 1, 0, 0); run_cycles("R3_R2", 0, 1100); endtask
  task automatic t_mck16;        mclk_oe = 1; start(8'd2, 1, 1, 0); run_cycles("R6_R5", 0, 1400); endtask
  task automatic t_mck32;        mclk_oe = 1; start(8'd1, 0, 1, 1); run_cycles("R6_R5", 0, 2100); endtask

  task automatic t_oe;
    mclk_oe = 1; start(8'd3, 0, 1, 1);
    run_cycles("R7", 0, 50);
    mclk_oe = 0; run_cycles("R7", 50, 50);
    mclk_oe = 1; run_cycles("R7", 100, 50);
  endtask

  task automatic t_capture;
    start(8'd3, 0, 0, 0);
    run_cycles("R8", 0, 40);
    div_i = 8'd10; odd_i = 1; wide_ch = 1; mclk_mode = 1;
    run_cycles("R8", 40, 100);
    start(8'd10, 1, 0, 1);
    run_cycles("R8_R9", 0, 100);
  endtask

  task automatic t_disable;
    start(8'd4, 0, 0, 0);
    run_cycles("R1", 0, 13);
    @(negedge clk); run_en = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R1", {mclk_o, bclk_o, bit_tick, frame_tick}, 4'b0000, i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk); t_reset;
    t_direct_even; t_direct_odd; t_clamp; t_max;
    t_mck16; t_mck32; t_oe; t_capture; t_disable;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule